// File: doc/BRIEF.md
# Display Identification Shadow Store

This block holds a local copy of a monitor's 128-byte identification block and serves it to several host-facing read ports at the same time. Every port gets an answer, whether or not its host is the one currently switched to the monitor. A capture port receives the bytes fetched from the monitor over the display-side link. The block checks each captured block for the fixed header, the exact length and a zero byte sum. It adopts the block only when all three checks pass.

Until a good block has been adopted, the hosts are served a profile built into the logic. Captured bytes go into a spare bank of a two-bank memory. A commit flips the active-bank pointer in a single clock edge, so a host never sees a half-written block. Each host port works like a serial display-data slave. The host writes a start offset, and each read returns one byte and steps the offset.

Top module: `edid_shadow_store`

## Requirements
- R1: During and just after reset, `src_is_display` is 0, every `host_rvalid` bit is 0, and every `host_rdata` byte is 00.
- R2: With no adopted capture, offsets 0 to 127 return the built-in profile. Bytes 0 to 7 are 00 FF FF FF FF FF FF 00. Byte n for 8 ≤ n ≤ 125 equals n. Byte 126 (the extension count) is 00. Byte 127 is 5F, which makes all 128 bytes sum to 0 modulo 256.
- R3: A cycle with `host_ofs_wr[h]` high loads the offset of port h from `host_ofs_data[h]`. A cycle with `host_rd[h]` high and `host_ofs_wr[h]` low returns the byte at the current offset on `host_rdata[h]`, with `host_rvalid[h]` high, after the next clock edge. The offset then goes up by one. `host_rdata[h]` holds its value between reads.
- R4: The offset of a host port wraps from 255 to 0.
- R5: Reads at offsets 128 to 255 always return FF.
- R6: A capture runs as follows. A `cap_start` pulse opens it. It carries exactly 128 `cap_valid` bytes, in offset order. A `cap_done` pulse ends it. If bytes 0 to 7 match the header and the 128 bytes sum to 0 modulo 256, the capture is adopted at the edge that samples `cap_done`. From the next read onward, all ports return the captured bytes, and `src_is_display` becomes 1.
- R7: A capture whose header bytes differ from the fixed pattern is discarded, and the previously served block stays in place.
- R8: A capture whose byte sum is not 0 modulo 256 is discarded, and the previously served block stays in place.
- R9: A capture with fewer or more than 128 bytes is discarded, and the previously served block stays in place.
- R10: All host ports return the served block at the same time, each from its own independent offset.
- R11: While a capture is in progress, host reads return the previously served block and none of the newly captured bytes.
- R12: Once `src_is_display` is 1, it stays 1 until reset, whatever later captures do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_start | input | 1 | Opens a new capture |
| cap_valid | input | 1 | A captured byte is present on `cap_data` |
| cap_data | input | 8 | Captured byte |
| cap_done | input | 1 | Closes the capture and requests validation |
| host_ofs_wr | input | NUM_HOSTS | Per-port offset load strobe |
| host_ofs_data | input | 8*NUM_HOSTS | Per-port offset value, port h in bits [8h+7:8h] |
| host_rd | input | NUM_HOSTS | Per-port byte read strobe |
| host_rdata | output | 8*NUM_HOSTS | Per-port read byte (registered) |
| host_rvalid | output | NUM_HOSTS | Per-port read byte valid |
| src_is_display | output | 1 | 1 when the served block came from the monitor |

## Verification
A read strobe sampled at edge k delivers its byte and valid flag after edge k. The bench therefore raises the strobe for one negative-edge-to-negative-edge window and samples at the following negative edge. An offset load takes one edge, so the first read goes in the window after it. A commit takes effect at the edge that samples `cap_done`. The bench checks `src_is_display` and issues its next read only in the window after that edge. Rejected captures are confirmed by reading back, through the host ports, bytes that the discarded block would have changed.

// File: rtl/edid_pkg.sv
package edid_pkg;

  // Fixed identification header value for positions 0..7
  function automatic logic [7:0] hdr_byte(input int idx);
    return (idx == 0 || idx == 7) ? 8'h00 : 8'hFF;
  endfunction

  // Built-in profile, every byte except the closing checksum
  function automatic logic [7:0] dflt_body(input int idx, input int blk);
    if (idx < 8)            return hdr_byte(idx);
    else if (idx == blk - 2) return 8'h00;
    else                    return 8'(idx);
  endfunction

  // Checksum that makes the built-in profile sum to zero
  function automatic logic [7:0] dflt_csum(input int blk);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < blk - 1; i++) s = s + dflt_body(i, blk);
    return 8'h00 - s;
  endfunction

endpackage

// File: rtl/edid_capture_check.sv
module edid_capture_check
  import edid_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  localparam int AW = $clog2(BLK_BYTES),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_start,
  input  logic          cap_valid,
  input  logic [7:0]    cap_data,
  input  logic          cap_done,
  output logic          wr_en,
  output logic [AW:0]   wr_addr,
  output logic [7:0]    wr_data,
  output logic          active_bank,
  output logic          from_display
);

  logic [CW-1:0] cnt;
  logic [7:0]    sum;
  logic          hdr_ok;
  logic          overrun;
  logic          blk_ok;
  logic          full;

  assign full    = (cnt == CW'(BLK_BYTES));
  assign blk_ok  = full && !overrun && hdr_ok && (sum == 8'h00);
  assign wr_en   = cap_valid && !cap_start && !cap_done && !full;
  assign wr_addr = {~active_bank, cnt[AW-1:0]};
  assign wr_data = cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      sum          <= 8'h00;
      hdr_ok       <= 1'b1;
      overrun      <= 1'b0;
      active_bank  <= 1'b0;
      from_display <= 1'b0;
    end else if (cap_start || cap_done) begin
      cnt     <= '0;
      sum     <= 8'h00;
      hdr_ok  <= 1'b1;
      overrun <= 1'b0;
      if (cap_done && blk_ok) begin
        active_bank  <= ~active_bank;
        from_display <= 1'b1;
      end
    end else if (cap_valid) begin
      if (full) begin
        overrun <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        sum <= sum + cap_data;
        if (cnt < CW'(8) && cap_data != hdr_byte(int'(cnt))) hdr_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/edid_host_port.sv
module edid_host_port #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ofs_wr,
  input  logic [OFS_W-1:0] ofs_data,
  input  logic             rd,
  output logic             rd_en,
  output logic [OFS_W-1:0] rd_addr,
  output logic             rvalid
);

  logic [OFS_W-1:0] ofs;

  assign rd_en   = rd && !ofs_wr;
  assign rd_addr = ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs    <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (ofs_wr)     ofs <= ofs_data;
      else if (rd_en) ofs <= ofs + 1'b1;
    end
  end

endmodule

// File: rtl/edid_shadow_mem.sv
module edid_shadow_mem
  import edid_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int NUM_HOSTS = 2,
  localparam int AW = $clog2(BLK_BYTES),
  localparam int OFS_W = AW + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW:0]                wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic                       active_bank,
  input  logic                       from_display,
  input  logic [NUM_HOSTS-1:0]       rd_en,
  input  logic [NUM_HOSTS*OFS_W-1:0] rd_addr,
  output logic [NUM_HOSTS*8-1:0]     rd_data
);

  localparam logic [7:0] DFLT_CSUM = dflt_csum(BLK_BYTES);

  logic [7:0] mem [0:2*BLK_BYTES-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_rd
    logic [OFS_W-1:0] a;
    logic [7:0]       dflt;
    logic [7:0]       q;
    assign a    = rd_addr[h*OFS_W +: OFS_W];
    assign dflt = (int'(a[AW-1:0]) == BLK_BYTES - 1) ? DFLT_CSUM
                                                      : dflt_body(int'(a[AW-1:0]), BLK_BYTES);
    always_ff @(posedge clk) begin
      if (rst)             q <= 8'h00;
      else if (rd_en[h]) begin
        if (a[AW])             q <= 8'hFF;
        else if (!from_display) q <= dflt;
        else                    q <= mem[{active_bank, a[AW-1:0]}];
      end
    end
    assign rd_data[h*8 +: 8] = q;
  end

endmodule

// File: rtl/edid_shadow_store.sv
module edid_shadow_store #(
  parameter int NUM_HOSTS = 2,
  parameter int BLK_BYTES = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap_start,
  input  logic                   cap_valid,
  input  logic [7:0]             cap_data,
  input  logic                   cap_done,
  input  logic [NUM_HOSTS-1:0]   host_ofs_wr,
  input  logic [NUM_HOSTS*8-1:0] host_ofs_data,
  input  logic [NUM_HOSTS-1:0]   host_rd,
  output logic [NUM_HOSTS*8-1:0] host_rdata,
  output logic [NUM_HOSTS-1:0]   host_rvalid,
  output logic                   src_is_display
);

  localparam int AW    = $clog2(BLK_BYTES);
  localparam int OFS_W = AW + 1;

  logic                       wr_en;
  logic [AW:0]                wr_addr;
  logic [7:0]                 wr_data;
  logic                       active_bank;
  logic [NUM_HOSTS-1:0]       rd_en;
  logic [NUM_HOSTS*OFS_W-1:0] rd_addr;

  edid_capture_check #(.BLK_BYTES(BLK_BYTES)) u_cap (
    .clk(clk), .rst(rst),
    .cap_start(cap_start), .cap_valid(cap_valid),
    .cap_data(cap_data), .cap_done(cap_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .active_bank(active_bank), .from_display(src_is_display)
  );

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_port
    edid_host_port #(.OFS_W(OFS_W)) u_port (
      .clk(clk), .rst(rst),
      .ofs_wr(host_ofs_wr[h]),
      .ofs_data(host_ofs_data[h*8 +: OFS_W]),
      .rd(host_rd[h]),
      .rd_en(rd_en[h]),
      .rd_addr(rd_addr[h*OFS_W +: OFS_W]),
      .rvalid(host_rvalid[h])
    );
  end

  edid_shadow_mem #(.BLK_BYTES(BLK_BYTES), .NUM_HOSTS(NUM_HOSTS)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .active_bank(active_bank), .from_display(src_is_display),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(host_rdata)
  );

endmodule

// File: rtl/edid_shadow_store_chk.sv
module edid_shadow_store_chk #(
  parameter int NUM_HOSTS = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cap_done,
  input logic [NUM_HOSTS-1:0]   host_ofs_wr,
  input logic [NUM_HOSTS*8-1:0] host_ofs_data,
  input logic [NUM_HOSTS-1:0]   host_rd,
  input logic [NUM_HOSTS*8-1:0] host_rdata,
  input logic [NUM_HOSTS-1:0]   host_rvalid,
  input logic                   src_is_display
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!src_is_display && host_rvalid == '0 && host_rdata == '0));

  assert_src_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    src_is_display |=> src_is_display);

  assert_src_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(src_is_display) |-> $past(cap_done));

  for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_chk
    assert_rvalid_follows_rd_R3: assert property (@(posedge clk) disable iff (rst)
      (host_rd[h] && !host_ofs_wr[h]) |=> host_rvalid[h]);

    assert_no_spurious_rvalid_R3: assert property (@(posedge clk) disable iff (rst)
      !(host_rd[h] && !host_ofs_wr[h]) |=> (!host_rvalid[h] && $stable(host_rdata[h*8 +: 8])));

    assert_upper_half_ff_R5: assert property (@(posedge clk) disable iff (rst)
      (host_ofs_wr[h] && host_ofs_data[h*8+7]) ##1 (host_rd[h] && !host_ofs_wr[h])
        |=> host_rdata[h*8 +: 8] == 8'hFF);
  end

endmodule

bind edid_shadow_store edid_shadow_store_chk #(.NUM_HOSTS(NUM_HOSTS)) u_chk (
  .clk(clk), .rst(rst), .cap_done(cap_done),
  .host_ofs_wr(host_ofs_wr), .host_ofs_data(host_ofs_data),
  .host_rd(host_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .src_is_display(src_is_display)
);

// File: tb/edid_shadow_store_tb.sv
module edid_shadow_store_tb;

  localparam int NH = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cap_start = 1'b0, cap_valid = 1'b0, cap_done = 1'b0;
  logic [7:0]    cap_data = 8'h00;
  logic [NH-1:0] host_ofs_wr = '0, host_rd = '0;
  logic [NH*8-1:0] host_ofs_data = '0;
  logic [NH*8-1:0] host_rdata;
  logic [NH-1:0] host_rvalid;
  logic          src_is_display;

  int checks = 0;
  int errors = 0;

  logic [7:0] blk [0:127];

  always #5 clk = ~clk;

  edid_shadow_store #(.NUM_HOSTS(NH), .BLK_BYTES(128)) u_dut (
    .clk(clk), .rst(rst),
    .cap_start(cap_start), .cap_valid(cap_valid), .cap_data(cap_data), .cap_done(cap_done),
    .host_ofs_wr(host_ofs_wr), .host_ofs_data(host_ofs_data),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .src_is_display(src_is_display)
  );

  // {host, offset, expected} against the built-in profile (R2, R5)
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'd0,   8'h00}, {1'b1, 8'd1,   8'hFF}, {1'b0, 8'd6,   8'hFF},
    {1'b1, 8'd7,   8'h00}, {1'b0, 8'd8,   8'h08}, {1'b1, 8'd64,  8'h40},
    {1'b0, 8'd125, 8'h7D}, {1'b1, 8'd126, 8'h00}, {1'b0, 8'd127, 8'h5F},
    {1'b1, 8'd128, 8'hFF}, {1'b0, 8'd200, 8'hFF}, {1'b1, 8'd254, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_at(input int h, input logic [7:0] o, input logic [7:0] exp, input string req);
    @(negedge clk);
    host_ofs_wr[h] = 1'b1;
    host_ofs_data[h*8 +: 8] = o;
    @(negedge clk);
    host_ofs_wr[h] = 1'b0;
    host_rd[h] = 1'b1;
    @(negedge clk);
    host_rd[h] = 1'b0;
    chk(req, host_rdata[h*8 +: 8], exp);
    chk(req, {7'b0, host_rvalid[h]}, 8'h01);
  endtask

  task automatic rd_next(input int h, input logic [7:0] exp, input string req);
    host_rd[h] = 1'b1;
    @(negedge clk);
    host_rd[h] = 1'b0;
    chk(req, host_rdata[h*8 +: 8], exp);
  endtask

  // Good block: header, byte i = i + pat, count 0, closing checksum
  task automatic build_blk(input logic [7:0] pat);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 128; i++) begin
      if (i < 8)         blk[i] = (i == 0 || i == 7) ? 8'h00 : 8'hFF;
      else if (i == 126) blk[i] = 8'h00;
      else if (i < 126)  blk[i] = 8'(i) + pat;
      if (i < 127) s = s + blk[i];
    end
    blk[127] = 8'h00 - s;
  endtask

  task automatic cap_open();
    @(negedge clk); cap_start = 1'b1;
    @(negedge clk); cap_start = 1'b0;
  endtask

  task automatic cap_bytes(input int from, input int to);
    for (int i = from; i <= to; i++) begin
      cap_valid = 1'b1;
      cap_data = (i < 128) ? blk[i] : 8'h00;
      @(negedge clk);
    end
    cap_valid = 1'b0;
  endtask

  task automatic cap_close();
    cap_done = 1'b1;
    @(negedge clk);
    cap_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 src", {7'b0, src_is_display}, 8'h00);
    chk("R1 rvalid", {6'b0, host_rvalid}, 8'h00);
    chk("R1 rdata0", host_rdata[7:0], 8'h00);
    chk("R1 rdata1", host_rdata[15:8], 8'h00);
    rst = 1'b0;

    for (int v = 0; v < 12; v++)
      rd_at(int'(VEC[v][16]), VEC[v][15:8], VEC[v][7:0], "R2/R5 table");

    // R4: wrap
    rd_at(0, 8'd255, 8'hFF, "R4 at 255");
    rd_next(0, 8'h00, "R4 wrap to 0");
    rd_next(0, 8'hFF, "R4 then 1");

    // R3: increment
    rd_at(1, 8'd8, 8'h08, "R3 start");
    rd_next(1, 8'h09, "R3 inc");
    rd_next(1, 8'h0A, "R3 inc2");

    // R6: good capture
    build_blk(8'h30);
    cap_open(); cap_bytes(0, 127); cap_close();
    chk("R6 src", {7'b0, src_is_display}, 8'h01);
    rd_at(0, 8'd8, 8'h38, "R6 byte8");
    rd_at(0, 8'd127, blk[127], "R6 csum");
    rd_at(1, 8'd8, 8'h38, "R10 host1 byte8");
    rd_at(1, 8'd100, 8'd100 + 8'h30, "R10 host1 byte100");
    rd_at(1, 8'd130, 8'hFF, "R5 upper after capture");

    // R7: bad header, sum kept zero
    build_blk(8'h50);
    blk[3] = 8'hFE; blk[127] = blk[127] + 8'h01;
    cap_open(); cap_bytes(0, 127); cap_close();
    rd_at(0, 8'd8, 8'h38, "R7 kept");
    chk("R12 src after R7", {7'b0, src_is_display}, 8'h01);

    // R8: bad sum
    build_blk(8'h51);
    blk[127] = blk[127] + 8'h01;
    cap_open(); cap_bytes(0, 127); cap_close();
    rd_at(1, 8'd9, 8'h39, "R8 kept");

    // R9: short and long
    build_blk(8'h52);
    cap_open(); cap_bytes(0, 126); cap_close();
    rd_at(0, 8'd10, 8'h3A, "R9 short kept");
    cap_open(); cap_bytes(0, 128); cap_close();
    rd_at(1, 8'd10, 8'h3A, "R9 long kept");
    chk("R12 src after R9", {7'b0, src_is_display}, 8'h01);

    // R11: reads during a capture see old block
    build_blk(8'h70);
    cap_open(); cap_bytes(0, 63);
    rd_at(1, 8'd9, 8'h39, "R11 mid capture");
    cap_bytes(64, 127); cap_close();
    rd_at(0, 8'd9, 8'h79, "R6 second commit");
    rd_at(1, 8'd9, 8'h79, "R10 second commit");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule